// File: doc/BRIEF.md
# Byte-Write Synchronous SRAM Core

This block is a behavioural synchronous static memory with 32-bit words held as four 8-bit byte lanes. The address, write data and all control inputs are captured on the rising clock edge. A write can store all four lanes at once through a global write strobe, or a chosen subset of lanes through a byte-write strobe and per-lane selects. Lanes that are not chosen keep their old contents. A read returns the word at the captured address. It reaches the data outputs either straight from the array (flow-through) or through one extra rising-edge output register (pipelined).

The output bus is modelled by a drive flag, `busOn`. `rdData` is forced to zero whenever the bus is not driven. A deselect turns the bus off at the first data stage after it is captured, so a read followed directly by a deselect never holds the bus for an extra cycle. Output enable acts without waiting for a clock. A sleep input freezes the block: commands are dropped, the bus is released and the array keeps its contents. After sleep is released, a parameterised number of recovery edges pass before the next command is accepted.

The array depth is `2**ADDR_W` words. A full-size part uses `ADDR_W = 16`, and smaller values suit simulation.

Top module: `bwsram_top`

## Requirements
- R1: A command sampled with `csN` low and `gwN` low writes all four lanes of `wrData` to `addr`, whatever the values of `bweN` and `laneSelN`.
- R2: A command sampled with `csN` low, `gwN` high and `bweN` low writes byte lane i (`wrData[8i+7:8i]`) only when `laneSelN[i]` is low. Every other lane of that word keeps its previous value, and with `laneSelN` = 4'hF nothing changes.
- R3: A command sampled with `csN` low and both `gwN` and `bweN` high is a read, and it returns the last value written to each lane of that word.
- R4: In flow-through mode (`pipeMode` = 0), the data of a read sampled at edge k is on `rdData` with `busOn` high from just after edge k until edge k+1.
- R5: In pipelined mode (`pipeMode` = 1), the data of a read sampled at edge k is on `rdData` with `busOn` high from just after edge k+1. Back-to-back reads deliver one word per clock.
- R6: A deselect (`csN` high) sampled at edge m leaves `busOn` low after edge m in flow-through mode and after edge m+1 in pipelined mode. `rdData` is zero whenever `busOn` is low, and the bus is off after reset.
- R7: `oeN` high forces `busOn` low and `rdData` to zero without waiting for a clock edge. `oeN` low turns the bus on only while a read result is due.
- R8: While `sleep` is high, sampled commands are ignored, `busOn` is low and the array contents are retained.
- R9: After `sleep` falls, the first `WAKE_CYCLES` edges sampled with `sleep` low ignore commands, and the next edge accepts one.
- R10: A write sampled at edge k is visible to a read of the same address sampled at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset of the control and address registers, active low |
| pipeMode | input | 1 | 1 = pipelined read path, 0 = flow-through |
| csN | input | 1 | Chip select, active low; high is a deselect |
| addr | input | ADDR_W | Word address |
| gwN | input | 1 | Global write, active low, writes all lanes |
| bweN | input | 1 | Byte-write enable, active low |
| laneSelN | input | 4 | Per-lane write selects, active low, bit i for byte lane i |
| wrData | input | 32 | Write data |
| oeN | input | 1 | Output enable, active low, acts without a clock edge |
| sleep | input | 1 | Sleep request, active high |
| rdData | output | 32 | Read data, zero while the bus is off |
| busOn | output | 1 | High while the block drives the data bus |

## Verification
The embedded properties run on every clock. They cover the lane mask that each write command produces under global or byte control, bus release after a deselect in each read mode, and the dropping of commands during sleep and during the recovery window. Only the bench scenarios show the data itself. This includes:
- merged byte contents after every lane-select pattern;
- exact first-word latency and one-word-per-clock streaming in both modes;
- write-then-read forwarding through the array;
- the clock-free reaction to output enable;
- retention of a word that a write during sleep tried to overwrite.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;
  localparam int LANES     = 4;
  localparam int LANE_BITS = 8;
  localparam int WORD_BITS = LANES * LANE_BITS;

  // Strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] wrLanes;  // lanes written at this edge
    logic             pLoad;    // load output register at this edge
    logic             flowSel;  // select array word instead of output register
    logic             outEn;    // drive the bus
  } strobe_t;
endpackage

// File: rtl/bwsram_ctrl.sv
module bwsram_ctrl
  import bwsram_pkg::*;
#(
  parameter int WAKE_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pipeMode,
  input  logic             csN,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] laneSelN,
  input  logic             oeN,
  input  logic             sleep,
  output strobe_t          stb
);
  localparam int CW = (WAKE_CYCLES < 1) ? 1 : $clog2(WAKE_CYCLES + 1);

  logic [CW-1:0]    wakeCnt;
  logic             accept;
  logic             isWrite;
  logic [LANES-1:0] laneHit;
  logic [LANES-1:0] wrQ;
  logic             rdQ;
  logic             pipeOn;

  always_comb begin
    accept  = !csN && !sleep && (wakeCnt == '0);
    isWrite = !gwN || !bweN;
    if (!gwN)       laneHit = '1;
    else if (!bweN) laneHit = ~laneSelN;
    else            laneHit = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakeCnt <= '0;
      wrQ     <= '0;
      rdQ     <= 1'b0;
      pipeOn  <= 1'b0;
    end else begin
      if (sleep)                wakeCnt <= CW'(WAKE_CYCLES);
      else if (wakeCnt != '0)   wakeCnt <= wakeCnt - 1'b1;
      wrQ    <= accept ? laneHit : '0;
      rdQ    <= accept && !isWrite;
      pipeOn <= rdQ;
    end
  end

  always_comb begin
    stb.wrLanes = wrQ;
    stb.pLoad   = rdQ;
    stb.flowSel = !pipeMode;
    stb.outEn   = (pipeMode ? pipeOn : rdQ) && !oeN && !sleep;
  end

  p_global_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !gwN && !sleep && wakeCnt == '0) |=> (stb.wrLanes == '1));

  p_lane_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && gwN && !bweN && !sleep && wakeCnt == '0) |=> (stb.wrLanes == ~$past(laneSelN)));

  p_flow_deselect_r6: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !pipeMode) |=> !stb.outEn);

  p_pipe_deselect_r6: assert property (@(posedge clk) disable iff (!rstN)
    (csN && pipeMode) |=> ##1 !stb.outEn);

  p_sleep_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> (stb.wrLanes == '0 && !stb.pLoad));

  p_wake_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wakeCnt != '0) |=> (stb.wrLanes == '0 && !stb.pLoad));
endmodule

// File: rtl/bwsram_dp.sv
module bwsram_dp
  import bwsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_BITS-1:0] wrData,
  input  strobe_t              stb,
  output logic [WORD_BITS-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0]    addrQ;
  logic [WORD_BITS-1:0] dataQ;
  logic [WORD_BITS-1:0] arrayWord;
  logic [WORD_BITS-1:0] outReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      addrQ <= addr;
      dataQ <= wrData;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_BITS-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (stb.wrLanes[g]) laneMem[addrQ] <= dataQ[g*LANE_BITS +: LANE_BITS];
    end
    assign arrayWord[g*LANE_BITS +: LANE_BITS] = laneMem[addrQ];
  end

  always_ff @(posedge clk) begin
    if (!rstN)          outReg <= '0;
    else if (stb.pLoad) outReg <= arrayWord;
  end

  assign rdData = stb.outEn ? (stb.flowSel ? arrayWord : outReg) : '0;

  p_bus_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.outEn |-> (rdData == '0));
endmodule

// File: rtl/bwsram_top.sv
module bwsram_top
  import bwsram_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int WAKE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              csN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [3:0]        laneSelN,
  input  logic [31:0]       wrData,
  input  logic              oeN,
  input  logic              sleep,
  output logic [31:0]       rdData,
  output logic              busOn
);
  strobe_t stb;

  bwsram_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .csN(csN), .gwN(gwN),
    .bweN(bweN), .laneSelN(laneSelN), .oeN(oeN), .sleep(sleep), .stb(stb)
  );

  bwsram_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .stb(stb),
    .rdData(rdData)
  );

  assign busOn = stb.outEn;
endmodule

// File: tb/tb_bwsram_top.sv
module tb_bwsram_top;
  localparam int AW    = 4;
  localparam int WORDS = 1 << AW;
  localparam int WAKE  = 3;

  logic clk = 1'b0;
  logic rstN, pipeMode, csN, gwN, bweN, oeN, sleep;
  logic [AW-1:0] addr;
  logic [3:0]    laneSelN;
  logic [31:0]   wrData, rdData;
  logic          busOn;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] shadow [WORDS];

  bwsram_top #(.ADDR_W(AW), .WAKE_CYCLES(WAKE)) dut (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .csN(csN), .addr(addr),
    .gwN(gwN), .bweN(bweN), .laneSelN(laneSelN), .wrData(wrData),
    .oeN(oeN), .sleep(sleep), .rdData(rdData), .busOn(busOn)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_bus(input string req, input logic expOn, input logic [31:0] expData);
    checks++;
    if (busOn !== expOn || rdData !== expData) begin
      failures++;
      $display("FAIL %s: actual busOn=%0b rdData=%h expected busOn=%0b rdData=%h",
               req, busOn, rdData, expOn, expData);
    end
  endtask

  task automatic idle();
    csN = 1'b1; gwN = 1'b1; bweN = 1'b1; laneSelN = 4'hF;
  endtask

  task automatic cmd_read(input int a);
    csN = 1'b0; gwN = 1'b1; bweN = 1'b1; laneSelN = 4'hF; addr = AW'(a);
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] selN);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) if (!selN[l]) r[l*8 +: 8] = nw[l*8 +: 8];
    return r;
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; pipeMode = 1'b1; oeN = 1'b0; sleep = 1'b0;
    addr = '0; wrData = '0; idle();
    repeat (3) tick();
    expect_bus("R6 reset", 1'b0, 32'h0);
    rstN = 1'b1;
    tick();
    expect_bus("R6 idle after reset", 1'b0, 32'h0);

    // R1: global write sweep, lane selects and byte enable scrambled
    for (int a = 0; a < WORDS; a++) begin
      csN = 1'b0; gwN = 1'b0; bweN = a[0]; laneSelN = 4'(a);
      addr = AW'(a);
      wrData = 32'(a) * 32'h01030507 + 32'h11223344;
      shadow[a] = wrData;
      tick();
    end
    idle(); repeat (2) tick();

    // R5/R3: pipelined burst of reads
    for (int i = 0; i < WORDS + 2; i++) begin
      if (i < WORDS) cmd_read(i); else idle();
      tick();
      if (i == 0) expect_bus("R7 no pending read", 1'b0, 32'h0);
      else if (i <= WORDS) expect_bus("R5 R1 R3 pipelined read", 1'b1, shadow[i-1]);
      else expect_bus("R6 pipelined deselect", 1'b0, 32'h0);
    end
    repeat (2) tick();

    // R4: flow-through burst
    pipeMode = 1'b0;
    tick();
    for (int i = 0; i < WORDS; i++) begin
      cmd_read(i);
      tick();
      expect_bus("R4 flow-through read", 1'b1, shadow[i]);
    end
    idle(); tick();
    expect_bus("R6 flow deselect", 1'b0, 32'h0);

    // R2/R10: every lane-select pattern, each followed at once by a read
    for (int m = 0; m < 16; m++) begin
      csN = 1'b0; gwN = 1'b1; bweN = 1'b0; laneSelN = 4'(m); addr = AW'(5);
      wrData = 32'(m) * 32'h10204080 ^ 32'hA5C31E69;
      shadow[5] = merge(shadow[5], wrData, 4'(m));
      tick();
      cmd_read(5);
      tick();
      expect_bus("R2 R10 byte lanes then read", 1'b1, shadow[5]);
    end
    idle(); tick();

    // R1: global write overrides deasserted lane selects
    csN = 1'b0; gwN = 1'b0; bweN = 1'b0; laneSelN = 4'hF; addr = AW'(6);
    wrData = 32'hC0FFEE42; shadow[6] = wrData;
    tick();
    cmd_read(6);
    tick();
    expect_bus("R1 global over lanes", 1'b1, 32'hC0FFEE42);
    idle(); tick();

    // R7: output enable acts without a clock
    oeN = 1'b1; cmd_read(3);
    tick();
    expect_bus("R7 oe high blocks", 1'b0, 32'h0);
    oeN = 1'b0;
    #1;
    expect_bus("R7 oe low enables pending read", 1'b1, shadow[3]);
    idle(); repeat (3) tick();

    // R8/R9: sleep drops a write, then recovery window
    pipeMode = 1'b1;
    repeat (3) tick();
    sleep = 1'b1;
    csN = 1'b0; gwN = 1'b0; addr = AW'(2); wrData = 32'hDEADBEEF;
    repeat (2) tick();
    expect_bus("R8 sleep bus off", 1'b0, 32'h0);
    cmd_read(2);
    tick(); tick();
    expect_bus("R8 sleep read ignored", 1'b0, 32'h0);
    sleep = 1'b0;
    for (int j = 1; j <= WAKE + 2; j++) begin
      tick();
      if (j == WAKE + 2) expect_bus("R9 R8 first read after recovery", 1'b1, shadow[2]);
      else expect_bus("R9 recovery ignores", 1'b0, 32'h0);
      if (j == WAKE + 1) idle();
    end
    tick();
    expect_bus("R6 pipelined off after last read", 1'b0, 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule